// File: doc/BRIEF.md
# Delay-Line Calibration Sequencer

This block is the control sequencer that measures two matched digitally tuned delay lines before a transmission starts. Each line takes a 9-bit coarse word and a 5-bit fine word. A phase detector compares the outputs of the two lines and reports whether line 2 leads or lags. The sequencer drives all four words, reads the detector, and extracts three figures in a fixed order. The first is the coarse word that spans one full reference period. The second is the fine word that completes that span. The third is the number of fine steps that equal one coarse step. It stores the three figures in result registers, where the phase-word mapper reads them.

In the coarse step, line 1 stays at zero and the detector compares line 2 against line 1 delayed by one reference period. The coarse word of line 2 is found by successive approximation. In the fine step, that coarse result is held and the fine word of line 2 is found the same way. In the ratio step, line 1 is set to one coarse step and the fine word of line 2 counts up until the detector reports that line 2 is late. A programmable settle time follows every codeword change, and the detector is read only after it. Pulsing start again before a later transmission re-measures all three figures.

Top module: `dl_cal_seq`

## Requirements
- R1: After reset, all four codeword outputs, busy, done, timeout and the three result registers are zero.
- R2: A start pulse while idle begins a run, and busy is high from the next cycle. A start pulse while busy is ignored and neither restarts nor lengthens the run.
- R3: In the coarse step, the line 1 words and the line 2 fine word are 0. The line 2 coarse word is searched MSB first. Each trial bit is kept only if UP is high when sampled, so the result is the largest coarse word for which UP holds.
- R4: In the fine step, the line 1 words are 0 and the line 2 coarse word holds the coarse result. The line 2 fine word is searched MSB first with the same keep-on-UP rule.
- R5: In the ratio step, the line 1 coarse word is 1 and the line 1 fine word and line 2 coarse word are 0. The line 2 fine word starts at 0 and rises by one per trial. The first trial that samples DOWN high ends the run, and that fine word becomes the ratio result.
- R6: If DOWN is still low on the trial at fine word 31 (all ones), the run ends with timeout high and ratio result 31. If DOWN is high on that trial, timeout stays low.
- R7: Each trial lasts settle_len+1 cycles, with detector outputs sampled on its last cycle. From the start edge to done, a run takes (9 + 5 + ratio result + 1) × (settle_len + 1) cycles.
- R8: The result registers keep their previous values throughout a run. They change only on the cycle that done rises.
- R9: done and timeout stay high until the next accepted start, which clears both. done and busy are never high together.
- R10: While idle, all four codeword outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (accepted only when idle) |
| settle_len | input | 8 | Wait cycles after each codeword change |
| pd_up | input | 1 | Detector: line 2 earlier than the target edge |
| pd_dn | input | 1 | Detector: line 2 later than the target edge |
| c1_code | output | 9 | Line 1 coarse word |
| f1_code | output | 5 | Line 1 fine word |
| c2_code | output | 9 | Line 2 coarse word |
| f2_code | output | 5 | Line 2 fine word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| timeout | output | 1 | Ratio step saw no DOWN |
| cm_res | output | 9 | Coarse full-period result |
| fm_res | output | 5 | Fine full-period result |
| beta_res | output | 5 | Fine steps per coarse step |

## Verification
The bench includes a detector model with a one-cycle lag. With this lag, a sequencer that samples before the settle time ends reads the previous trial's decision, and its results disagree with the brute-force expected values. The corner cases are reference periods at the extremes: the smallest one must give all-zero full-period words, and the largest must saturate both searches to all ones. Step ratios of 30 and 31 fine units separate a late DOWN seen on the last trial from a true timeout; an off-by-one in the limit test misreports the timeout flag or the ratio. Each run also pulses start mid-run and checks that the results are unchanged before done. A design that restarts or commits results early fails the latency or hold checks.

// File: rtl/dl_cal_pkg.sv
package dl_cal_pkg;
    localparam int COARSE_W = 9;
    localparam int FINE_W   = 5;
    localparam int SETTLE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2,
        PH_RATIO  = 2'd3
    } phase_e;

    // Trials in a run for a given ratio result.
    function automatic int run_trials(input int cw, input int fw, input int ratio);
        return cw + fw + ratio + 1;
    endfunction
endpackage

// File: rtl/dl_cal_sar.sv
module dl_cal_sar #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         keep,
    output logic [W-1:0] code,
    output logic         last
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            mask <= '0;
        end else if (load) begin
            code <= TOP_BIT;
            mask <= TOP_BIT;
        end else if (step) begin
            code <= (keep ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
        end
    end

    assign last = mask[0];

    // R3 / R4: at most one trial bit under test at any time
    a_r3_mask_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));

    // R3 / R4: a rejected trial bit is cleared
    a_r3_reject_clears: assert property (@(posedge clk) disable iff (rst)
        step && !load && !keep |=> (code & $past(mask)) == '0);

    // R4: an accepted trial bit survives
    a_r4_accept_keeps: assert property (@(posedge clk) disable iff (rst)
        step && !load && keep |=> (code & $past(mask)) == $past(mask));
endmodule

// File: rtl/dl_cal_settle.sv
module dl_cal_settle #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] len,
    output logic          ready
);
    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);

    // R7: the wait counts down one per cycle until the sample point
    a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
        !load && !ready |=> cnt == $past(cnt) - 1'b1);

    // R7: once ready and not reloaded, stays ready
    a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
        !load && ready |=> ready);
endmodule

// File: rtl/dl_cal_seq.sv
module dl_cal_seq
    import dl_cal_pkg::*;
#(
    parameter int CW = COARSE_W,
    parameter int FW = FINE_W,
    parameter int SW = SETTLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] settle_len,
    input  logic          pd_up,
    input  logic          pd_dn,
    output logic [CW-1:0] c1_code,
    output logic [FW-1:0] f1_code,
    output logic [CW-1:0] c2_code,
    output logic [FW-1:0] f2_code,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [CW-1:0] cm_res,
    output logic [FW-1:0] fm_res,
    output logic [FW-1:0] beta_res
);
    localparam logic [FW-1:0] RATIO_MAX = '1;
    localparam logic [CW-1:0] ONE_COARSE = CW'(1);

    phase_e        ph;
    logic [FW-1:0] ratio_cnt;
    logic [CW-1:0] c_code;
    logic [FW-1:0] f_code;
    logic          c_last, f_last, tmr_ready;
    logic          go, decide, c_step, f_step, r_step, finish, t_load;

    assign go     = (ph == PH_IDLE) && start;
    assign decide = (ph != PH_IDLE) && tmr_ready;
    assign c_step = decide && (ph == PH_COARSE);
    assign f_step = decide && (ph == PH_FINE);
    assign r_step = decide && (ph == PH_RATIO);
    assign finish = r_step && (pd_dn || ratio_cnt == RATIO_MAX);
    assign t_load = go || (decide && !finish);

    dl_cal_sar #(.W(CW)) u_coarse (
        .clk(clk), .rst(rst), .load(go), .step(c_step), .keep(pd_up),
        .code(c_code), .last(c_last)
    );

    dl_cal_sar #(.W(FW)) u_fine (
        .clk(clk), .rst(rst), .load(c_step && c_last), .step(f_step), .keep(pd_up),
        .code(f_code), .last(f_last)
    );

    dl_cal_settle #(.SW(SW)) u_settle (
        .clk(clk), .rst(rst), .load(t_load), .len(settle_len), .ready(tmr_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            ratio_cnt <= '0;
            done      <= 1'b0;
            timeout   <= 1'b0;
            cm_res    <= '0;
            fm_res    <= '0;
            beta_res  <= '0;
        end else begin
            if (go) begin
                ph      <= PH_COARSE;
                done    <= 1'b0;
                timeout <= 1'b0;
            end
            if (c_step && c_last) ph <= PH_FINE;
            if (f_step && f_last) begin
                ph        <= PH_RATIO;
                ratio_cnt <= '0;
            end
            if (finish) begin
                ph       <= PH_IDLE;
                done     <= 1'b1;
                timeout  <= !pd_dn;
                cm_res   <= c_code;
                fm_res   <= f_code;
                beta_res <= ratio_cnt;
            end else if (r_step) begin
                ratio_cnt <= ratio_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        c1_code = '0;
        f1_code = '0;
        c2_code = '0;
        f2_code = '0;
        case (ph)
            PH_COARSE: c2_code = c_code;
            PH_FINE: begin
                c2_code = c_code;
                f2_code = f_code;
            end
            PH_RATIO: begin
                c1_code = ONE_COARSE;
                f2_code = ratio_cnt;
            end
            default: ;
        endcase
    end

    assign busy = (ph != PH_IDLE);

    // R8: results move only together with done
    a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> done || ($stable(cm_res) && $stable(fm_res) && $stable(beta_res)));

    // R6: timeout is only reported on a finished run
    a_r6_timeout_done: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done);

    // R9: busy and done exclusive
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R5: ratio word advances by exactly one per completed trial
    a_r5_ratio_step: assert property (@(posedge clk) disable iff (rst)
        r_step && !finish |=> f2_code == $past(f2_code) + 1'b1);

    // R5: ratio word steady while settling
    a_r5_ratio_steady: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RATIO) && !decide |=> $stable(f2_code));

    // R2: a start while busy does not restart the coarse search
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && !finish |=> busy);
endmodule

// File: tb/dl_cal_seq_bench.sv
module dl_cal_seq_bench;
    localparam int CW = 9;
    localparam int FW = 5;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [SW-1:0] settle_len;
    logic          pd_up, pd_dn;
    logic [CW-1:0] c1_code, c2_code, cm_res;
    logic [FW-1:0] f1_code, f2_code, fm_res, beta_res;
    logic          busy, done, timeout;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int cs_u   = 10;
    int fs_u   = 3;
    int tref_u = 100;

    always #4 clk = ~clk;

    dl_cal_seq u_dl_cal_seq (
        .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
        .pd_up(pd_up), .pd_dn(pd_dn),
        .c1_code(c1_code), .f1_code(f1_code), .c2_code(c2_code), .f2_code(f2_code),
        .busy(busy), .done(done), .timeout(timeout),
        .cm_res(cm_res), .fm_res(fm_res), .beta_res(beta_res)
    );

    // Delay lines and detector, with one register of lag.
    always @(posedge clk) begin
        int d1, d2, tgt;
        d1  = int'(c1_code) * cs_u + int'(f1_code) * fs_u;
        d2  = int'(c2_code) * cs_u + int'(f2_code) * fs_u;
        tgt = (c1_code == '0) ? d1 + tref_u : d1;
        if (rst) begin
            pd_up <= 1'b0;
            pd_dn <= 1'b0;
        end else begin
            pd_up <= (d2 < tgt);
            pd_dn <= (d2 > tgt);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cm(input int cs, input int tref);
        for (int c = 511; c >= 0; c--) if (c * cs < tref) return c;
        return 0;
    endfunction

    function automatic int exp_fm(input int cm, input int cs, input int fs, input int tref);
        for (int f = 31; f >= 0; f--) if (cm * cs + f * fs < tref) return f;
        return 0;
    endfunction

    function automatic int exp_beta(input int cs, input int fs);
        for (int f = 0; f <= 31; f++) if (f * fs > cs) return f;
        return 32; // marks timeout
    endfunction

    task automatic run_cal(input int cs, input int fs, input int tref, input int s);
        int n, ecm, efm, eb, eto, ebeta, elat;
        logic [CW-1:0] old_cm;
        logic [FW-1:0] old_fm, old_b;
        cs_u = cs; fs_u = fs; tref_u = tref;
        ecm   = exp_cm(cs, tref);
        efm   = exp_fm(ecm, cs, fs, tref);
        eb    = exp_beta(cs, fs);
        eto   = (eb == 32) ? 1 : 0;
        ebeta = (eb == 32) ? 31 : eb;
        elat  = (9 + 5 + ebeta + 1) * (s + 1);
        old_cm = cm_res; old_fm = fm_res; old_b = beta_res;
        @(negedge clk);
        settle_len = SW'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        chk(done === 1'b0 && timeout === 1'b0, "R9 start clears done/timeout",
            int'(done) + int'(timeout), 0);
        n = 0;
        while (!done && n < 5000) begin
            if (n == 2) start = 1'b1;
            if (n == 3) start = 1'b0;
            if (n == 5) chk(cm_res == old_cm && fm_res == old_fm && beta_res == old_b,
                            "R8 results held mid-run", int'(cm_res), int'(old_cm));
            @(negedge clk);
            n++;
        end
        chk(n == elat, "R7 run latency", n, elat);
        chk(int'(cm_res) == ecm, "R3 coarse result", int'(cm_res), ecm);
        chk(int'(fm_res) == efm, "R4 fine result", int'(fm_res), efm);
        chk(int'(beta_res) == ebeta, "R5 ratio result", int'(beta_res), ebeta);
        chk(int'(timeout) == eto, "R6 timeout flag", int'(timeout), eto);
        chk(busy === 1'b0, "R9 busy low with done", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(done === 1'b1, "R9 done holds", int'(done), 1);
        chk(c1_code == '0 && f1_code == '0 && c2_code == '0 && f2_code == '0,
            "R10 idle codewords zero", int'(c2_code) + int'(f2_code) + int'(c1_code), 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        rst = 1'b1;
        start = 1'b0;
        settle_len = 8'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(c1_code == '0 && f1_code == '0 && c2_code == '0 && f2_code == '0,
            "R1 reset codewords", int'(c2_code), 0);
        chk(busy === 1'b0 && done === 1'b0 && timeout === 1'b0, "R1 reset flags",
            int'(busy) + int'(done) + int'(timeout), 0);
        chk(cm_res == '0 && fm_res == '0 && beta_res == '0, "R1 reset results",
            int'(cm_res), 0);

        // Directed corners
        run_cal(40, 4, 1, 1);             // R3 R4 smallest period: all zero
        run_cal(40, 4, 40 * 600, 2);      // R3 R4 saturate to all ones
        run_cal(5 * 30, 5, 9000, 1);      // R6 DOWN on last trial, no timeout
        run_cal(5 * 31, 5, 9000, 3);      // R6 no DOWN: timeout
        run_cal(6 * 7, 6, 6 * 7 * 3, 1);  // R5 coarse step exactly 7 fine steps

        // Random runs
        for (int i = 0; i < 10; i++) begin
            int fs, cs, tref, s;
            fs   = 2 + int'($urandom % 6);
            cs   = fs * (2 + int'($urandom % 39));
            tref = 1 + int'($urandom % (cs * 520));
            s    = 1 + int'($urandom % 4);
            run_cal(cs, fs, tref, s);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule